// File: doc/BRIEF.md
# Boundary scan test access port controller

This block is the serial test port of a device. A test clock, a mode select line and a serial data input drive it. It steps through the standard sixteen-state test port sequence. It holds a three-bit instruction and places one of three data paths between the serial input and the serial output: a one-bit bypass stage, a 32-bit identification word, or a 107-bit boundary chain. The boundary chain loads a parallel snapshot of the device pins and, when it commits, drives a parallel vector back toward the pins.

A board-level tester uses the block to read the identity of the device and to sample or force pin values. It can also tell the device's own outputs to float while the chain is scanned. The serial output changes only on the falling edge of the test clock, and it carries an enable so that several devices can share one serial line. A power-on reset input puts the port into its reset state. Holding the mode line high for five clocks does the same from any state.

Top module: `scan_test_port`

## Requirements
- R1: The state follows the standard sixteen-state test port graph, advancing on the mode line value sampled at each rising test clock edge. Five consecutive rising edges with the mode line high reach Test-Logic-Reset from any state.
- R2: The active instruction is IDCODE (code 001) after power-on reset, and again from the first rising edge spent in Test-Logic-Reset. The identification word is 32 bits with the default value 0x0A5C3069. Bit 0 is forced to 1 and bits 31:29 (revision) are 000. It is shifted out least significant bit first.
- R3: The instruction register is 3 bits. Capture-IR loads 001, which is shifted out least significant bit first. A shifted-in code takes effect only at Update-IR.
- R4: The instruction decode is 000 EXTEST, 001 IDCODE, 010 SAMPLE Z and 100 SAMPLE/PRELOAD. Codes 011, 101, 110 and 111 all select the bypass stage.
- R5: The bypass stage is one bit long and captures 0 in Capture-DR.
- R6: Under EXTEST, SAMPLE Z or SAMPLE/PRELOAD, Capture-DR loads the 107-bit captureVec into the boundary chain. Bit 0 sits next to the serial output, and serial input enters at bit 106.
- R7: Update-DR copies the boundary chain onto bsrUpdate only under the three boundary instructions. Any other instruction leaves bsrUpdate unchanged.
- R8: forceHighZ is high exactly while SAMPLE Z is the active instruction. It rises only after an Update-IR.
- R9: tdoEn is high only while the port is in Shift-IR or Shift-DR. Both tdo and tdoEn change on the falling test clock edge.
- R10: An active-low power-on reset clears bsrUpdate, tdoEn and forceHighZ and puts the state machine in Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| powerOnRstN | input | 1 | Asynchronous active-low power-on reset |
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| captureVec | input | 107 | Parallel pin snapshot for boundary capture |
| tdo | output | 1 | Serial data out, valid when tdoEn is high |
| tdoEn | output | 1 | Output enable for tdo |
| forceHighZ | output | 1 | Request to float the device outputs (SAMPLE Z) |
| bsrUpdate | output | 107 | Parallel vector committed at Update-DR |

## Verification
The bench builds the block with its default parameters: a 107-bit chain and the 32-bit identification word 0x0A5C3069. Each of the eight instruction codes therefore gets a full 140-bit scan. This length shows the exact length of every chain, its captured contents and the delayed echo of the shifted-in data. The fixed length also makes the worst-case five-clock escape from Shift-DR and the half-cycle offset of the serial output observable cycle by cycle.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic selBsr;
    logic selId;
  } tapStrobe_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rstN,
  input  logic            tms,
  input  logic            tdi,
  output tapStrobe_t      strobe,
  output logic            irTdo,
  output logic [IR_W-1:0] irActive,
  output logic            forceHighZ,
  output tapState_e       tapState
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  tapState_e       nextState;
  logic [IR_W-1:0] irShift;

  always_comb begin
    case (tapState)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) tapState <= ST_RESET;
    else       tapState <= nextState;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                      irShift <= '0;
    else if (tapState == ST_CAP_IR) irShift <= IR_CAPTURE;
    else if (tapState == ST_SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                      irActive <= OP_IDCODE;
    else if (tapState == ST_RESET)  irActive <= OP_IDCODE;
    else if (tapState == ST_UPD_IR) irActive <= irShift;
  end

  assign irTdo = irShift[0];
  assign forceHighZ = (irActive == OP_SAMPLEZ);

  always_comb begin
    strobe.captureDr = (tapState == ST_CAP_DR);
    strobe.shiftDr   = (tapState == ST_SH_DR);
    strobe.updateDr  = (tapState == ST_UPD_DR);
    strobe.shiftIr   = (tapState == ST_SH_IR);
    strobe.selBsr    = (irActive == OP_EXTEST) || (irActive == OP_SAMPLEZ) ||
                       (irActive == OP_SAMPLE);
    strobe.selId     = (irActive == OP_IDCODE);
  end

endmodule

// File: rtl/scan_tap_data.sv
module scan_tap_data
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 107,
  parameter int          ID_LEN   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_3069
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tdi,
  input  tapStrobe_t         strobe,
  input  logic               irTdo,
  input  logic [BSR_LEN-1:0] captureVec,
  output logic               tdo,
  output logic               tdoEn,
  output logic [BSR_LEN-1:0] bsrUpdate
);

  localparam logic [ID_LEN-1:0] ID_CAPTURE = {ID_VALUE[ID_LEN-1:1], 1'b1};

  logic               bypassBit;
  logic [ID_LEN-1:0]  idShift;
  logic [BSR_LEN-1:0] bsrShift;
  logic               selBypass;
  logic               serialBit;

  assign selBypass = !strobe.selBsr && !strobe.selId;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                               bypassBit <= 1'b0;
    else if (strobe.captureDr && selBypass)  bypassBit <= 1'b0;
    else if (strobe.shiftDr && selBypass)    bypassBit <= tdi;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                                idShift <= ID_CAPTURE;
    else if (strobe.captureDr && strobe.selId) idShift <= ID_CAPTURE;
    else if (strobe.shiftDr && strobe.selId)   idShift <= {tdi, idShift[ID_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                                  bsrShift <= '0;
    else if (strobe.captureDr && strobe.selBsr) bsrShift <= captureVec;
    else if (strobe.shiftDr && strobe.selBsr)   bsrShift <= {tdi, bsrShift[BSR_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                                 bsrUpdate <= '0;
    else if (strobe.updateDr && strobe.selBsr) bsrUpdate <= bsrShift;
  end

  always_comb begin
    if (strobe.shiftIr)     serialBit = irTdo;
    else if (strobe.selBsr) serialBit = bsrShift[0];
    else if (strobe.selId)  serialBit = idShift[0];
    else                    serialBit = bypassBit;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialBit;
      tdoEn <= strobe.shiftIr || strobe.shiftDr;
    end
  end

endmodule

// File: rtl/scan_test_port.sv
module scan_test_port
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 107,
  parameter int          ID_LEN   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_3069
) (
  input  logic               powerOnRstN,
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] captureVec,
  output logic               tdo,
  output logic               tdoEn,
  output logic               forceHighZ,
  output logic [BSR_LEN-1:0] bsrUpdate
);

  tapStrobe_t      strobe;
  logic            irTdo;
  logic [IR_W-1:0] irActive;
  tapState_e       tapState;

  scan_tap_ctrl u_ctrl (
    .tck        (tck),
    .rstN       (powerOnRstN),
    .tms        (tms),
    .tdi        (tdi),
    .strobe     (strobe),
    .irTdo      (irTdo),
    .irActive   (irActive),
    .forceHighZ (forceHighZ),
    .tapState   (tapState)
  );

  scan_tap_data #(
    .BSR_LEN  (BSR_LEN),
    .ID_LEN   (ID_LEN),
    .ID_VALUE (ID_VALUE)
  ) u_data (
    .tck        (tck),
    .rstN       (powerOnRstN),
    .tdi        (tdi),
    .strobe     (strobe),
    .irTdo      (irTdo),
    .captureVec (captureVec),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .bsrUpdate  (bsrUpdate)
  );

endmodule

// File: rtl/scan_test_port_chk.sv
module scan_test_port_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 107
) (
  input logic               tck,
  input logic               powerOnRstN,
  input logic               tms,
  input logic               tdoEn,
  input logic               forceHighZ,
  input logic [BSR_LEN-1:0] bsrUpdate,
  input tapState_e          tapState,
  input logic [IR_W-1:0]    irActive
);

  logic [2:0] tmsRun;
  logic       boundaryOp;

  always_ff @(posedge tck or negedge powerOnRstN) begin
    if (!powerOnRstN) tmsRun <= 3'd0;
    else if (tms)     tmsRun <= (tmsRun == 3'd7) ? 3'd7 : tmsRun + 3'd1;
    else              tmsRun <= 3'd0;
  end

  assign boundaryOp = (irActive == OP_EXTEST) || (irActive == OP_SAMPLEZ) ||
                      (irActive == OP_SAMPLE);

  AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!powerOnRstN)
    (tmsRun >= 3'd5) |-> (tapState == ST_RESET)); // R1

  AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!powerOnRstN)
    (tapState == ST_RESET) |=> (irActive == OP_IDCODE)); // R2

  AST_UPDATE_HELD: assert property (@(posedge tck) disable iff (!powerOnRstN)
    !((tapState == ST_UPD_DR) && boundaryOp) |=> $stable(bsrUpdate)); // R7

  AST_HIGHZ_AFTER_UPDATE_IR: assert property (@(posedge tck) disable iff (!powerOnRstN)
    $rose(forceHighZ) |-> ($past(tapState) == ST_UPD_IR)); // R8

  AST_TDO_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (!powerOnRstN)
    tdoEn |-> ((tapState == ST_SH_DR) || (tapState == ST_SH_IR))); // R9

endmodule

bind scan_test_port scan_test_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck         (tck),
  .powerOnRstN (powerOnRstN),
  .tms         (tms),
  .tdoEn       (tdoEn),
  .forceHighZ  (forceHighZ),
  .bsrUpdate   (bsrUpdate),
  .tapState    (tapState),
  .irActive    (irActive)
);

// File: tb/scan_test_port_tb.sv
module scan_test_port_tb;

  localparam int CLK_PERIOD = 20;
  localparam int BSR_LEN    = 107;
  localparam int SCAN_N     = 140;
  localparam logic [31:0] ID_EXP = 32'h0A5C_3069;

  // entry: {code[5:3], highZ[2], kind[1:0]}; kind 0 bypass, 1 id, 2 boundary
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 1'b0, 2'd2}, {3'b001, 1'b0, 2'd1}, {3'b010, 1'b1, 2'd2},
    {3'b011, 1'b0, 2'd0}, {3'b100, 1'b0, 2'd2}, {3'b101, 1'b0, 2'd0},
    {3'b110, 1'b0, 2'd0}, {3'b111, 1'b0, 2'd0}
  };

  logic               powerOnRstN, tck, tms, tdi;
  logic [BSR_LEN-1:0] captureVec;
  logic               tdo, tdoEn, forceHighZ;
  logic [BSR_LEN-1:0] bsrUpdate;

  int checks = 0;
  int errors = 0;
  logic [BSR_LEN-1:0] expUpd;

  scan_test_port u_dut (
    .powerOnRstN (powerOnRstN),
    .tck         (tck),
    .tms         (tms),
    .tdi         (tdi),
    .captureVec  (captureVec),
    .tdo         (tdo),
    .tdoEn       (tdoEn),
    .forceHighZ  (forceHighZ),
    .bsrUpdate   (bsrUpdate)
  );

  initial begin
    tck = 1'b0;
    forever #(CLK_PERIOD / 2) tck = ~tck;
  end

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic goIdle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [2:0] code, output logic [2:0] capBits);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      capBits[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic scanDr(input logic [SCAN_N-1:0] inPat, output logic [SCAN_N-1:0] outBits);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < SCAN_N; i++) begin
      outBits[i] = tdo;
      tick(i == SCAN_N - 1, inPat[i]);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  function automatic logic [SCAN_N-1:0] expChain(input logic [SCAN_N-1:0] capt,
                                                 input int len,
                                                 input logic [SCAN_N-1:0] inPat);
    logic [SCAN_N-1:0] r;
    for (int i = 0; i < SCAN_N; i++) r[i] = (i < len) ? capt[i] : inPat[i - len];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0]      wide;
    logic [159:0]      patWide;
    logic [SCAN_N-1:0] inPat, outBits, capt;
    logic [2:0]        irCap;
    int                len;

    wide = {4{32'hC0DE_5A37}};
    patWide = {5{32'h9E37_79B9}};
    captureVec = wide[BSR_LEN-1:0];
    powerOnRstN = 1'b0;
    tms = 1'b1;
    tdi = 1'b0;
    expUpd = '0;
    #(CLK_PERIOD * 2 + 3);
    // R10: reset state of outputs
    chk("R10 tdoEn", 160'(tdoEn), 160'(0));
    chk("R10 forceHighZ", 160'(forceHighZ), 160'(0));
    chk("R10 bsrUpdate", 160'(bsrUpdate), 160'(0));
    @(negedge tck);
    powerOnRstN = 1'b1;
    #1;

    goIdle();
    chk("R9 tdoEn idle", 160'(tdoEn), 160'(0));
    // R2: IDCODE selected after power-on without any IR load
    inPat = patWide[SCAN_N-1:0];
    scanDr(inPat, outBits);
    chk("R2 idcode after power-on", 160'(outBits),
        160'(expChain(SCAN_N'(ID_EXP), 32, inPat)));
    chk("R2 id bit0 and revision", 160'({outBits[31:29], outBits[0]}), 160'(4'b0001));

    // table walk over all instruction codes
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code;
      code = VEC[v][5:3];
      captureVec = wide[BSR_LEN-1:0] ^ {BSR_LEN{code[1]}};
      inPat = patWide[SCAN_N-1:0] ^ {SCAN_N{code[0]}} ^ (SCAN_N'(code) << 50);
      loadIr(code, irCap);
      chk("R3 ir capture 001", 160'(irCap), 160'(3'b001));
      chk("R8 forceHighZ per code", 160'(forceHighZ), 160'(VEC[v][2]));
      case (VEC[v][1:0])
        2'd0:    begin capt = '0;                  len = 1;       end
        2'd1:    begin capt = SCAN_N'(ID_EXP);     len = 32;      end
        default: begin capt = SCAN_N'(captureVec); len = BSR_LEN; end
      endcase
      scanDr(inPat, outBits);
      if (VEC[v][1:0] == 2'd0)
        chk("R4 R5 bypass chain", 160'(outBits), 160'(expChain(capt, len, inPat)));
      else if (VEC[v][1:0] == 2'd1)
        chk("R4 R2 id chain", 160'(outBits), 160'(expChain(capt, len, inPat)));
      else
        chk("R4 R6 boundary chain", 160'(outBits), 160'(expChain(capt, len, inPat)));
      if (VEC[v][1:0] == 2'd2) expUpd = inPat[SCAN_N-1:SCAN_N-BSR_LEN];
      chk("R7 update vector", 160'(bsrUpdate), 160'(expUpd));
    end

    // R9: tdo and tdoEn move on the falling edge only
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tms = 1'b0;
    @(posedge tck);
    #1;
    chk("R9 tdoEn before falling edge", 160'(tdoEn), 160'(0));
    @(negedge tck);
    #1;
    chk("R9 tdoEn after falling edge", 160'(tdoEn), 160'(1));
    chk("R9 R3 tdo ir lsb", 160'(tdo), 160'(1));
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R3 R8 code 010 taken at update", 160'(forceHighZ), 160'(1));
    chk("R9 tdoEn idle again", 160'(tdoEn), 160'(0));

    // R1: five high edges from Shift-DR reach reset, then R2 IDCODE returns
    captureVec = wide[BSR_LEN-1:0];
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    expUpd = {1'b0, captureVec[BSR_LEN-1:1]};
    tick(1'b0, 1'b0);
    chk("R1 R8 highZ cleared by tms reset", 160'(forceHighZ), 160'(0));
    chk("R7 update from exit path", 160'(bsrUpdate), 160'(expUpd));
    inPat = ~patWide[SCAN_N-1:0];
    scanDr(inPat, outBits);
    chk("R1 R2 idcode after tms reset", 160'(outBits),
        160'(expChain(SCAN_N'(ID_EXP), 32, inPat)));
    chk("R7 update unchanged under idcode", 160'(bsrUpdate), 160'(expUpd));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule